// File: doc/BRIEF.md
# SPI Receive Capture Delay Selector

This block sits in the receive path of an SPI master whose serial clock is the module clock itself, with no divider in between. At high serial rates the data returning on MISO arrives late relative to the clock edge that launched it, so the point at which the receive bit is captured has to move later as the rate goes up. The block offers three capture timings: on the nominal sampling edge, half a clock period later on the opposite edge, or one full period later on the next edge of the same polarity.

The shift engine raises a one-cycle strobe, `smp_stb`, in the cycle whose rising edge is the nominal sampling edge. The block captures MISO at the point the selected timing calls for. It then hands the bit to the shift register as `rx_bit` together with a one-cycle `rx_vld` pulse, so every strobe yields exactly one valid bit whatever the timing. Two control bits from the transfer-control register choose the timing. They are taken in only while no transfer is running. Choosing the timing from the serial rate is left to software: on-edge capture suits rates up to about 24 MHz, half-cycle capture suits rates up to about 40 MHz, and full-cycle capture suits 80 MHz and above.

Top module: `spi_rx_capture_delay`

## Requirements
- R1: After reset `rx_vld` and `rx_bit` are 0, and the capture timing is half-cycle until the control bits are first taken in while `busy` is low.
- R2: With `sel_edge`=1 and `sel_late`=0 (on-edge timing), a strobe at rising edge T captures MISO as seen at edge T; `rx_vld`=1 and `rx_bit` hold that value in the cycle after edge T.
- R3: With `sel_edge`=0 and `sel_late`=0 (half-cycle timing), a strobe at rising edge T captures MISO at the falling edge that follows T; `rx_vld`=1 and `rx_bit` hold that value in the cycle after rising edge T+1.
- R4: With `sel_edge`=0 and `sel_late`=1 (full-cycle timing), a strobe at rising edge T captures MISO at rising edge T+1; `rx_vld`=1 and `rx_bit` hold that value in the cycle after edge T+1.
- R5: `sel_edge`=1 with `sel_late`=1 is reserved and gives the on-edge timing of R2.
- R6: The control bits are taken in at a rising edge only when `busy` is low; changes while `busy` is high have no effect on the capture timing.
- R7: Each strobe gives exactly one `rx_vld` pulse, and strobes on consecutive edges give valid pulses on consecutive cycles in every timing.
- R8: `rx_bit` keeps its last captured value in every cycle in which `rx_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock, also driven out as the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miso | input | 1 | Serial receive data line |
| smp_stb | input | 1 | One-cycle strobe marking the nominal sampling edge |
| busy | input | 1 | High while a transfer is in progress |
| sel_edge | input | 1 | Control bit: 1 selects on-edge capture |
| sel_late | input | 1 | Control bit: with `sel_edge`=0, 1 selects full-cycle capture, 0 half-cycle |
| rx_bit | output | 1 | Captured receive bit |
| rx_vld | output | 1 | One-cycle pulse: `rx_bit` holds a new bit |

## Verification
An on-edge result is due one rising edge after its strobe. Half-cycle and full-cycle results are due two rising edges after it, and the bit for those comes from MISO at the intervening falling edge or at the second rising edge. The bench therefore drives MISO to a fresh random value shortly after every rising and every falling edge, so the three timings expect different bits. It samples the outputs one nanosecond after each rising edge. Its model tracks, per edge, the strobe, the timing that was in force, and both MISO values, and from these it predicts `rx_vld` and `rx_bit` for that exact edge.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
package rxd_pkg;

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_HALF = 2'd1,
    MODE_FULL = 2'd2
  } rxd_mode_e;

  // Control-bit decode; the reserved pair (1,1) falls into on-edge capture.
  function automatic rxd_mode_e rxd_decode(input logic on_edge, input logic late);
    if (on_edge)   return MODE_NORM;
    else if (late) return MODE_FULL;
    else           return MODE_HALF;
  endfunction

endpackage

// File: rtl/rxd_mode_reg.sv
`timescale 1ns/1ps
module rxd_mode_reg
  import rxd_pkg::*;
#(
  parameter rxd_mode_e RST_MODE = MODE_HALF
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      busy,
  input  logic      sel_edge,
  input  logic      sel_late,
  output rxd_mode_e mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= RST_MODE;
    else if (!busy) mode_q <= rxd_decode(sel_edge, sel_late);
  end

  // R6: timing frozen while a transfer runs
  a_r6_mode_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));

  // R5: reserved control pair lands in on-edge capture
  a_r5_reserved_is_norm: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sel_edge && sel_late) |=> (mode_q == MODE_NORM));

endmodule

// File: rtl/rxd_half_path.sv
`timescale 1ns/1ps
module rxd_half_path (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic miso,
  output logic arm_q,
  output logic neg_flag,
  output logic neg_data
);

  // Rising edge: remember that the nominal edge carried a strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= hit;
  end

  // Falling edge half a period later: capture the line and the marker.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_flag <= 1'b0;
      neg_data <= 1'b0;
    end else begin
      neg_flag <= arm_q;
      neg_data <= miso;
    end
  end

endmodule

// File: rtl/rxd_full_path.sv
`timescale 1ns/1ps
module rxd_full_path (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic pend_q
);

  // One period of delay on the marker; the line is taken at the next edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= hit;
  end

endmodule

// File: rtl/spi_rx_capture_delay.sv
`timescale 1ns/1ps
module spi_rx_capture_delay
  import rxd_pkg::*;
#(
  parameter rxd_mode_e RST_MODE   = MODE_HALF,
  parameter logic      RX_RST_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic miso,
  input  logic smp_stb,
  input  logic busy,
  input  logic sel_edge,
  input  logic sel_late,
  output logic rx_bit,
  output logic rx_vld
);

  rxd_mode_e mode_q;
  logic      hit_norm, hit_half, hit_full;
  logic      half_arm, half_flag, half_data;
  logic      full_pend;

  rxd_mode_reg #(.RST_MODE(RST_MODE)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .sel_edge (sel_edge),
    .sel_late (sel_late),
    .mode_q   (mode_q)
  );

  // Route each strobe to exactly one timing path.
  assign hit_norm = smp_stb && (mode_q == MODE_NORM);
  assign hit_half = smp_stb && (mode_q == MODE_HALF);
  assign hit_full = smp_stb && (mode_q == MODE_FULL);

  rxd_half_path u_half (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit_half),
    .miso     (miso),
    .arm_q    (half_arm),
    .neg_flag (half_flag),
    .neg_data (half_data)
  );

  rxd_full_path u_full (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit_full),
    .pend_q (full_pend)
  );

  // Merge: all paths retire on a rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_vld <= 1'b0;
      rx_bit <= RX_RST_BIT;
    end else begin
      rx_vld <= hit_norm | half_flag | full_pend;
      if (full_pend)      rx_bit <= miso;
      else if (half_flag) rx_bit <= half_data;
      else if (hit_norm)  rx_bit <= miso;
    end
  end

  // R2: on-edge capture takes the line at the strobe edge
  a_r2_norm_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hit_norm |=> (rx_vld && rx_bit == $past(miso)));

  // R3: half-cycle marker always retires one edge later
  a_r3_half_retire: assert property (@(posedge clk) disable iff (!rst_n)
    half_arm |=> rx_vld);

  // R4: full-cycle capture takes the line one period after the strobe
  a_r4_full_arm: assert property (@(posedge clk) disable iff (!rst_n)
    hit_full |=> full_pend);
  a_r4_full_capture: assert property (@(posedge clk) disable iff (!rst_n)
    full_pend |=> (rx_vld && rx_bit == $past(miso)));

  // R7: no valid without a strobe one or two edges earlier
  a_r7_vld_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |-> ($past(smp_stb) || $past(smp_stb, 2)));

  // R8: bit only moves together with a valid pulse
  a_r8_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_vld |-> $stable(rx_bit));

endmodule

// File: tb/spi_rx_capture_delay_tb_top.sv
`timescale 1ns/1ps
module spi_rx_capture_delay_tb_top;

  logic clk = 1'b0;
  logic rst_n, miso, smp_stb, busy, sel_edge, sel_late;
  logic rx_bit, rx_vld;

  always #2.5 clk = ~clk;

  spi_rx_capture_delay dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .miso     (miso),
    .smp_stb  (smp_stb),
    .busy     (busy),
    .sel_edge (sel_edge),
    .sel_late (sel_late),
    .rx_bit   (rx_bit),
    .rx_vld   (rx_vld)
  );

  int    checks = 0;
  int    errors = 0;
  string ph = "-";

  // Bench model state. Timing codes: 0 on-edge, 1 half-cycle, 2 full-cycle.
  int         mode_b = 1;
  int         prev_mode = 1;
  logic       prev_s = 1'b0;
  logic       drv_s = 1'b0, drv_busy = 1'b0;
  logic [1:0] drv_sel = 2'b00;
  logic       cur_p = 1'b0, n_last = 1'b0, bit_hold = 1'b0;

  function automatic int bench_mode(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s: got %0b expected %0b at %0t", req, ph, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic s_nx, input logic b_nx, input logic [1:0] sel_nx);
    drv_s = s_nx; drv_busy = b_nx; drv_sel = sel_nx;
    smp_stb = s_nx; busy = b_nx; {sel_edge, sel_late} = sel_nx;
  endtask

  task automatic step(input logic s_nx, input logic b_nx, input logic [1:0] sel_nx);
    int    m_i;
    logic  ev, eb;
    string rq;
    @(posedge clk);
    m_i = mode_b;
    ev = 1'b0; eb = bit_hold; rq = "R8";
    if (drv_s && m_i == 0)        begin ev = 1'b1; eb = cur_p;  rq = "R2"; end
    if (prev_s && prev_mode == 1) begin ev = 1'b1; eb = n_last; rq = "R3"; end
    if (prev_s && prev_mode == 2) begin ev = 1'b1; eb = cur_p;  rq = "R4"; end
    if (!drv_busy) mode_b = bench_mode(drv_sel);
    prev_s = drv_s; prev_mode = m_i; bit_hold = eb;
    #1;
    chk(rq, "rx_vld", rx_vld, ev);
    chk(rq, "rx_bit", rx_bit, eb);
    n_last = 1'($urandom % 2);
    miso = n_last;
    drive(s_nx, b_nx, sel_nx);
    @(negedge clk);
    #1;
    cur_p = 1'($urandom % 2);
    miso = cur_p;
  endtask

  // Idle with sel_idle, a busy stretch (sel_busy from step 'sw' on), then drain.
  task automatic run(input int n, input logic [1:0] sel_idle, input logic [1:0] sel_busy,
                     input int sw, input int dens);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, sel_idle);
    for (int i = 0; i < n; i++)
      step(1'(($urandom % 100) < dens), 1'b1, (i >= sw) ? sel_busy : sel_idle);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, sel_idle);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0; miso = 1'b0; smp_stb = 1'b0; busy = 1'b0;
    sel_edge = 1'b0; sel_late = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    ph = "R1";
    chk("R1", "rx_vld reset", rx_vld, 1'b0);
    chk("R1", "rx_bit reset", rx_bit, 1'b0);
    // R1: keep busy high from release, so the reset timing (half-cycle) stays in force
    rst_n = 1'b1;
    drive(1'b0, 1'b1, 2'b10);
    @(negedge clk);
    #1;
    cur_p = 1'($urandom % 2);
    miso = cur_p;
    for (int i = 0; i < 20; i++) step(1'(i % 3 == 0), 1'b1, 2'b10);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 2'b10);

    ph = "R2"; run(150, 2'b10, 2'b10, 0, 50);
    ph = "R3"; run(150, 2'b00, 2'b00, 0, 50);
    ph = "R4"; run(150, 2'b01, 2'b01, 0, 50);
    ph = "R5"; run(150, 2'b11, 2'b11, 0, 50);

    // R7: strobes on every edge in each timing
    ph = "R7"; run(40, 2'b10, 2'b10, 0, 100);
    ph = "R7"; run(40, 2'b00, 2'b00, 0, 100);
    ph = "R7"; run(40, 2'b01, 2'b01, 0, 100);

    // R6: control bits change mid-transfer and must be ignored
    ph = "R6"; run(60, 2'b01, 2'b10, 10, 60);
    ph = "R6"; run(60, 2'b10, 2'b00, 5,  60);
    ph = "R6"; run(60, 2'b00, 2'b01, 20, 60);

    // Random mix of timings, densities and mid-transfer changes
    ph = "rand";
    for (int k = 0; k < 16; k++)
      run(20 + int'($urandom % 60), 2'($urandom % 4), 2'($urandom % 4),
          int'($urandom % 30), 10 + int'($urandom % 91));

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

endmodule